// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Vector Unit

This block runs the acknowledge phase of an interrupt controller that can serve as the head of a cascade or as one of the devices hanging off it. Once the winning interrupt level has been picked elsewhere, the processor sends a train of acknowledge pulses. On each pulse the unit decides whether this device puts a byte on the data bus and which byte that is. In the master role it also announces the serviced level on a three-bit cascade bus. In the slave role it compares that bus with its own identity.

Two processor modes are supported. The 8-bit call mode uses three pulses: an opcode byte, then a low and a high address byte. The 16-bit vectored mode uses two pulses, and only the second one carries a vector byte. When the serviced master input has a slave behind it, the matching slave supplies the address or vector bytes. The master still supplies the call opcode and still drives the cascade bus.

The acknowledge strobe is sampled on the block clock. Every output comes straight from a register or from decode of register state, so the outputs change only at a clock edge.

Top module: `cascade_ack_vector`

## Requirements
- R1: While reset is held and directly after it, `data_oe` and `cas_oe` are 0, and `data_out` and `cas_out` are 0.
- R2: In the master role, `cas_oe` is 1 from the first pulse of a sequence until the end of its last pulse. During that time `cas_out` carries the level that was captured at the first pulse. In the slave role, `cas_oe` stays 0.
- R3: In call mode (`wide_mode`=0), the master drives 0xCD on the first pulse. It does this whether or not the serviced input has a slave.
- R4: In call mode, for a master input whose `cascade_cfg` bit is 0, the master drives the level multiplied by 4 on pulse two (the level sits in bits 4:2, all other bits are 0). On pulse three it drives `vec_base`.
- R5: In call mode, for a master input whose `cascade_cfg` bit is 1, the master leaves `data_oe` low on pulses two and three.
- R6: In the slave role with call mode, the unit drives the pulse-two and pulse-three bytes, built as in R4 from its own captured level, only when `cas_in` equals `cascade_cfg[2:0]`. It never drives on pulse one.
- R7: In vectored mode (`wide_mode`=1), a sequence is two pulses long and the first pulse drives no data. On pulse two the byte is `{vec_base[7:3], level}`. The master drives it for an input without a slave; a slave drives it when its identity matches.
- R8: `data_oe` rises only at the first clock edge that samples `ack_strobe_n` low. It falls at the first edge that samples the strobe high again.
- R9: After the rising edge of the last pulse of a mode, the unit returns to idle. The next falling strobe starts a new sequence at pulse one and captures a new level.
- R10: If `irq_level` changes after the first pulse of a sequence, the cascade code and the bytes of that sequence do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| role_master | input | 1 | 1 = cascade master, 0 = cascade slave |
| cascade_cfg | input | 8 | Master: one bit per input, 1 = slave attached. Slave: bits 2:0 hold its identity |
| wide_mode | input | 1 | 0 = 8-bit call mode (3 pulses), 1 = 16-bit vectored mode (2 pulses) |
| vec_base | input | 8 | Call mode: high address byte. Vectored mode: bits 7:3 are the type bits |
| irq_level | input | 3 | Winning interrupt level |
| ack_strobe_n | input | 1 | Acknowledge strobe, active low |
| cas_in | input | 3 | Cascade bus as seen by a slave |
| cas_out | output | 3 | Cascade code driven by a master |
| cas_oe | output | 1 | Drive enable for `cas_out` |
| data_out | output | 8 | Byte released onto the data bus |
| data_oe | output | 1 | Drive enable for `data_out` |

## Verification
The master is run in call mode and in vectored mode, each with a plain input and with a slaved input. This separates the byte it always owns (the opcode) from the bytes it hands over to a slave. The slave is run with a matching and with a mismatching cascade code in both modes, which shows that identity alone decides whether it drives. One sequence changes the level input after the first pulse, to confirm that the captured level is the one used. Sequences are also run back to back, so a missed return to idle would show up as a wrong first byte. Every pulse is sampled both while the strobe is low and after it is released, which catches enable timing errors.

// File: rtl/civ_pkg.sv
package civ_pkg;

    localparam int LVL_W         = 3;
    localparam int NUM_IN        = 1 << LVL_W;
    localparam int DATA_W        = 8;
    localparam int ADDR_INTERVAL = 4;
    localparam int IVL_SHIFT     = $clog2(ADDR_INTERVAL);

    localparam logic [DATA_W-1:0] CALL_OPCODE = 8'hCD;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_1    = 2'd1,
        PH_2    = 2'd2,
        PH_3    = 2'd3
    } ack_phase_e;

    typedef struct packed {
        logic  oe;
        byte_t val;
    } bus_byte_t;

    function automatic ack_phase_e last_phase(input logic wide);
        return wide ? PH_2 : PH_3;
    endfunction

    function automatic byte_t call_low_byte(input lvl_t lvl);
        byte_t t;
        t = byte_t'(lvl) << IVL_SHIFT;
        return t;
    endfunction

    function automatic byte_t vect_byte(input byte_t base, input lvl_t lvl);
        return {base[DATA_W-1:LVL_W], lvl};
    endfunction

endpackage

// File: rtl/civ_ack_seq.sv
module civ_ack_seq
    import civ_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe_n,
    input  logic       wide_mode,
    output ack_phase_e phase,
    output logic       strobe_low,
    output logic       start_pulse,
    output logic       any_fall
);

    logic strobe_q;
    logic fall;
    logic rise;

    always_comb begin
        fall        = strobe_q & ~strobe_n;
        rise        = ~strobe_q & strobe_n;
        start_pulse = fall && (phase == PH_IDLE);
        any_fall    = fall;
        strobe_low  = ~strobe_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b1;
            phase    <= PH_IDLE;
        end else begin
            strobe_q <= strobe_n;
            if (fall) begin
                unique case (phase)
                    PH_IDLE: phase <= PH_1;
                    PH_1:    phase <= PH_2;
                    PH_2:    phase <= wide_mode ? PH_2 : PH_3;
                    PH_3:    phase <= PH_3;
                endcase
            end else if (rise && (phase == last_phase(wide_mode))) begin
                phase <= PH_IDLE;
            end
        end
    end

    // R9: a new sequence always starts at pulse one
    a_r9_start: assert property (@(posedge clk) disable iff (rst)
        (fall && phase == PH_IDLE) |=> (phase == PH_1));

    // R9: release of the final pulse returns to idle
    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        (rise && phase == last_phase(wide_mode)) |=> (phase == PH_IDLE));

    // R7: vectored mode never reaches a third pulse
    a_r7_two_pulses: assert property (@(posedge clk) disable iff (rst)
        (wide_mode && $stable(wide_mode) && phase != PH_3) |=> (phase != PH_3));

endmodule

// File: rtl/civ_cascade.sv
module civ_cascade
    import civ_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              role_master,
    input  logic [NUM_IN-1:0] cfg,
    input  lvl_t              level,
    input  lvl_t              cas_in,
    input  logic              start_pulse,
    input  logic              any_fall,
    input  logic              active,
    output lvl_t              lvl_q,
    output logic              slaved,
    output logic              hit,
    output lvl_t              cas_out,
    output logic              cas_oe
);

    logic hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            hit_q <= 1'b0;
        end else begin
            if (start_pulse) begin
                lvl_q <= level;
            end
            if (any_fall) begin
                hit_q <= (cas_in == cfg[LVL_W-1:0]);
            end
        end
    end

    always_comb begin
        slaved  = role_master & cfg[lvl_q];
        hit     = ~role_master & hit_q;
        cas_oe  = role_master & active;
        cas_out = cas_oe ? lvl_q : '0;
    end

    // R2: cascade code holds steady through a sequence
    a_r2_cas_hold: assert property (@(posedge clk) disable iff (rst)
        (cas_oe && $past(cas_oe)) |-> $stable(cas_out));

    // R10: captured level only reloads at a sequence start
    a_r10_latched: assert property (@(posedge clk) disable iff (rst)
        ($past(active) && $past(!start_pulse)) |-> $stable(lvl_q));

endmodule

// File: rtl/civ_vec_build.sv
module civ_vec_build
    import civ_pkg::*;
(
    input  ack_phase_e phase,
    input  logic       strobe_low,
    input  logic       role_master,
    input  logic       wide_mode,
    input  logic       slaved,
    input  logic       hit,
    input  lvl_t       lvl_q,
    input  byte_t      vec_base,
    output byte_t      data_out,
    output logic       data_oe
);

    bus_byte_t pick;

    always_comb begin
        pick = '0;
        if (phase != PH_IDLE && strobe_low) begin
            if (role_master) begin
                if (!wide_mode) begin
                    unique case (phase)
                        PH_1: pick = '{oe: 1'b1, val: CALL_OPCODE};
                        PH_2: if (!slaved) pick = '{oe: 1'b1, val: call_low_byte(lvl_q)};
                        PH_3: if (!slaved) pick = '{oe: 1'b1, val: vec_base};
                        default: pick = '0;
                    endcase
                end else if (phase == PH_2 && !slaved) begin
                    pick = '{oe: 1'b1, val: vect_byte(vec_base, lvl_q)};
                end
            end else if (hit) begin
                if (!wide_mode) begin
                    unique case (phase)
                        PH_2:    pick = '{oe: 1'b1, val: call_low_byte(lvl_q)};
                        PH_3:    pick = '{oe: 1'b1, val: vec_base};
                        default: pick = '0;
                    endcase
                end else if (phase == PH_2) begin
                    pick = '{oe: 1'b1, val: vect_byte(vec_base, lvl_q)};
                end
            end
        end
        data_oe  = pick.oe;
        data_out = pick.val;
    end

endmodule

// File: rtl/cascade_ack_vector.sv
module cascade_ack_vector
    import civ_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              role_master,
    input  logic [NUM_IN-1:0] cascade_cfg,
    input  logic              wide_mode,
    input  logic [DATA_W-1:0] vec_base,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic              ack_strobe_n,
    input  logic [LVL_W-1:0]  cas_in,
    output logic [LVL_W-1:0]  cas_out,
    output logic              cas_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    ack_phase_e phase;
    logic       strobe_low;
    logic       start_pulse;
    logic       any_fall;
    lvl_t       lvl_q;
    logic       slaved;
    logic       hit;

    civ_ack_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .strobe_n    (ack_strobe_n),
        .wide_mode   (wide_mode),
        .phase       (phase),
        .strobe_low  (strobe_low),
        .start_pulse (start_pulse),
        .any_fall    (any_fall)
    );

    civ_cascade u_cas (
        .clk         (clk),
        .rst         (rst),
        .role_master (role_master),
        .cfg         (cascade_cfg),
        .level       (irq_level),
        .cas_in      (cas_in),
        .start_pulse (start_pulse),
        .any_fall    (any_fall),
        .active      (phase != PH_IDLE),
        .lvl_q       (lvl_q),
        .slaved      (slaved),
        .hit         (hit),
        .cas_out     (cas_out),
        .cas_oe      (cas_oe)
    );

    civ_vec_build u_vec (
        .phase       (phase),
        .strobe_low  (strobe_low),
        .role_master (role_master),
        .wide_mode   (wide_mode),
        .slaved      (slaved),
        .hit         (hit),
        .lvl_q       (lvl_q),
        .vec_base    (vec_base),
        .data_out    (data_out),
        .data_oe     (data_oe)
    );

    // R8: data drive begins only after the strobe was sampled low
    a_r8_oe_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(data_oe) |-> ($past(ack_strobe_n) == 1'b0));

    // R8: data drive ends once the strobe was sampled high
    a_r8_oe_fall: assert property (@(posedge clk) disable iff (rst)
        ($past(ack_strobe_n) == 1'b1) |-> !data_oe);

    // R3: the first call-mode byte from a master is the opcode
    a_r3_opcode: assert property (@(posedge clk) disable iff (rst)
        (role_master && !wide_mode && phase == PH_1 && data_oe) |-> (data_out == CALL_OPCODE));

    // R6: a slave never drives on the first pulse
    a_r6_slave_first: assert property (@(posedge clk) disable iff (rst)
        (!role_master && phase == PH_1) |-> !data_oe);

    // R2: a slave never drives the cascade bus
    a_r2_slave_cas: assert property (@(posedge clk) disable iff (rst)
        !role_master |-> !cas_oe);

endmodule

// File: tb/cascade_ack_vector_bench.sv
module cascade_ack_vector_bench;
    import civ_pkg::*;

    logic clk = 1'b0;
    logic rst;
    always #2.5 clk = ~clk;

    logic        role_master;
    logic [7:0]  cascade_cfg;
    logic        wide_mode;
    logic [7:0]  vec_base;
    logic [2:0]  irq_level;
    logic        ack_strobe_n;
    logic [2:0]  cas_in;
    logic [2:0]  cas_out;
    logic        cas_oe;
    logic [7:0]  data_out;
    logic        data_oe;

    cascade_ack_vector u_cascade_ack_vector (
        .clk(clk), .rst(rst), .role_master(role_master), .cascade_cfg(cascade_cfg),
        .wide_mode(wide_mode), .vec_base(vec_base), .irq_level(irq_level),
        .ack_strobe_n(ack_strobe_n), .cas_in(cas_in), .cas_out(cas_out),
        .cas_oe(cas_oe), .data_out(data_out), .data_oe(data_oe)
    );

    typedef struct {
        logic       doe;
        logic [7:0] d;
        logic       coe;
        logic [2:0] c;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   errors = 0;
    event smp;

    // expected bus state for pulse p, sampled while low or after release
    function automatic exp_t model(input logic role, input logic wide, input logic [7:0] cfg,
                                   input logic [7:0] base, input logic [2:0] lv,
                                   input logic [2:0] cin, input int p, input logic low,
                                   input string tag);
        exp_t e;
        int   n;
        logic owner;
        logic [7:0] lo;
        logic [7:0] vb;
        n     = wide ? 2 : 3;
        lo    = {3'b000, lv, 2'b00};
        vb    = {base[7:3], lv};
        e.tag = tag;
        e.doe = 1'b0;
        e.d   = 8'h00;
        e.coe = role && (low || p < n);
        e.c   = e.coe ? lv : 3'd0;
        owner = role ? !cfg[lv] : (cin == cfg[2:0]);
        if (low) begin
            if (!wide) begin
                if (p == 1 && role)       begin e.doe = 1'b1; e.d = 8'hCD; end
                else if (p == 2 && owner) begin e.doe = 1'b1; e.d = lo;    end
                else if (p == 3 && owner) begin e.doe = 1'b1; e.d = base;  end
            end else if (p == 2 && owner) begin
                e.doe = 1'b1; e.d = vb;
            end
        end
        return e;
    endfunction

    // monitor: compare design outputs with the queued expectation
    initial begin
        forever begin
            @(smp);
            if (sbq.size() != 0) begin
                exp_t e;
                e = sbq.pop_front();
                checks++;
                if ({data_oe, data_out, cas_oe, cas_out} !== {e.doe, e.d, e.coe, e.c}) begin
                    errors++;
                    $display("FAIL %s: got data_oe=%0b data=%02h cas_oe=%0b cas=%0d, expected data_oe=%0b data=%02h cas_oe=%0b cas=%0d",
                             e.tag, data_oe, data_out, cas_oe, cas_out, e.doe, e.d, e.coe, e.c);
                end
            end
        end
    end

    // driver: run one full acknowledge sequence and queue expectations
    task automatic run_seq(input logic role, input logic wide, input logic [7:0] cfg,
                           input logic [7:0] base, input logic [2:0] lv,
                           input logic [2:0] cin, input string tag,
                           input bit swap, input logic [2:0] other);
        int n;
        n = wide ? 2 : 3;
        @(negedge clk);
        role_master = role; wide_mode = wide; cascade_cfg = cfg;
        vec_base = base; irq_level = lv; cas_in = cin;
        for (int p = 1; p <= n; p++) begin
            @(negedge clk);
            ack_strobe_n = 1'b0;
            @(negedge clk);
            sbq.push_back(model(role, wide, cfg, base, lv, cin, p, 1'b1, tag));
            -> smp;
            ack_strobe_n = 1'b1;
            @(negedge clk);
            sbq.push_back(model(role, wide, cfg, base, lv, cin, p, 1'b0, tag));
            -> smp;
            if (swap && p == 1) irq_level = other;
        end
    endtask

    task automatic direct_check(input string tag, input logic ok);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got data_oe=%0b data=%02h cas_oe=%0b cas=%0d, expected all zero",
                     tag, data_oe, data_out, cas_oe, cas_out);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got no finish, expected end of run");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; role_master = 1'b1; cascade_cfg = 8'h00; wide_mode = 1'b0;
        vec_base = 8'h00; irq_level = 3'd0; ack_strobe_n = 1'b1; cas_in = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        direct_check("R1 in reset", !data_oe && !cas_oe && data_out == 8'h00 && cas_out == 3'd0);
        rst = 1'b0;
        @(negedge clk);
        direct_check("R1 after reset", !data_oe && !cas_oe && data_out == 8'h00 && cas_out == 3'd0);

        // R3 R4 R8: master, call mode, plain input
        run_seq(1'b1, 1'b0, 8'h00, 8'h3A, 3'd5, 3'd0, "R4 master call plain", 1'b0, 3'd0);
        // R3 R5: master, call mode, slaved input
        run_seq(1'b1, 1'b0, 8'h04, 8'h3A, 3'd2, 3'd0, "R5 master call slaved", 1'b0, 3'd0);
        // R7: master vectored, plain and slaved
        run_seq(1'b1, 1'b1, 8'h00, 8'h48, 3'd6, 3'd0, "R7 master vect plain", 1'b0, 3'd0);
        run_seq(1'b1, 1'b1, 8'h40, 8'h48, 3'd6, 3'd0, "R7 master vect slaved", 1'b0, 3'd0);
        // R6: slave call, match and mismatch
        run_seq(1'b0, 1'b0, 8'h03, 8'h80, 3'd1, 3'd3, "R6 slave call match", 1'b0, 3'd0);
        run_seq(1'b0, 1'b0, 8'h03, 8'h80, 3'd1, 3'd4, "R6 slave call mismatch", 1'b0, 3'd0);
        // R7 R2: slave vectored, match and mismatch
        run_seq(1'b0, 1'b1, 8'h07, 8'hF8, 3'd7, 3'd7, "R7 slave vect match", 1'b0, 3'd0);
        run_seq(1'b0, 1'b1, 8'h07, 8'hF8, 3'd7, 3'd2, "R7 slave vect mismatch", 1'b0, 3'd0);
        // R10: level changes after pulse one
        run_seq(1'b1, 1'b0, 8'h00, 8'h91, 3'd3, 3'd0, "R10 level held", 1'b1, 3'd0);
        // R9: back to back sequences with new levels
        run_seq(1'b1, 1'b1, 8'h00, 8'h20, 3'd1, 3'd0, "R9 back to back a", 1'b0, 3'd0);
        run_seq(1'b1, 1'b1, 8'h00, 8'h20, 3'd4, 3'd0, "R9 back to back b", 1'b0, 3'd0);
        run_seq(1'b1, 1'b0, 8'h00, 8'hFF, 3'd7, 3'd0, "R9 back to back c", 1'b0, 3'd0);

        repeat (3) @(negedge clk);
        direct_check("R9 idle at end", !data_oe && !cas_oe);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule